// File: doc/BRIEF.md
# Relocating Address Window Guard

This block maps program-relative addresses into absolute memory addresses. It also confines each program to a contiguous window of memory. The program context loads two registers, a window base and a window end. Every request from the issue pipeline carries a relative address and a tag that says whether it is an instruction fetch or a data operand access. The block adds the base to the relative address. It then checks the sum against the window end and either forwards the absolute address with a valid strobe or rejects the access.

Both window registers keep only the upper bits of an address. The low `GRAN_BITS` bits are taken as zero, so the window starts and ends on 16-word boundaries with the default parameters. A rejected access sets one of two sticky error flags, chosen by the access tag. While either flag is set, a halt output tells the issue stage to stop. The flags stay set until the controller pulses a clear input.

Top module: `reloc_guard`

## Requirements
- R1: After reset, the base and window end registers are both zero, both error flags are low, `halt_issue` is low and `abs_vld` is low.
- R2: A request with `req_vld` high produces `abs_addr = req_addr + (base << 4)` one clock later. `abs_vld` is high for exactly that cycle when the access is inside the window.
- R3: The window end is exclusive. An absolute address equal to `end << 4` or above it is out of range, and the address `(end << 4) - 1` is in range.
- R4: If the 22-bit sum carries out, the access is out of range, even when the low 22 bits of the sum are below the window end.
- R5: An out-of-range request with `req_kind = 0` (instruction fetch) sets `prog_err` only. An out-of-range request with `req_kind = 1` (operand) sets `oper_err` only.
- R6: An out-of-range access is not forwarded: `abs_vld` stays low in the cycle after it.
- R7: The error flags stay set until `err_clr` is pulsed. When a new fault and `err_clr` arrive in the same cycle, the flag of the new fault ends up set.
- R8: `halt_issue` is high in every cycle in which either error flag is high, and low otherwise.
- R9: A register load takes effect for requests in later cycles. A request in the same cycle as a load uses the old value, and translation never changes the registers.
- R10: A cycle with `req_vld` low produces no `abs_vld` pulse and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Load the window base register |
| base_in | input | 18 | New window base, in upper address bits |
| end_we | input | 1 | Load the window end register |
| end_in | input | 18 | New exclusive window end, in upper address bits |
| req_vld | input | 1 | Address request present |
| req_kind | input | 1 | 0 = instruction fetch, 1 = operand access |
| req_addr | input | 22 | Program-relative address |
| err_clr | input | 1 | Clear both error flags |
| abs_vld | output | 1 | Absolute address forwarded this cycle |
| abs_addr | output | 22 | Absolute address |
| prog_err | output | 1 | Sticky instruction-fetch range error |
| oper_err | output | 1 | Sticky operand range error |
| halt_issue | output | 1 | Stop instruction issue while any flag is set |

## Verification
The translated address, the valid strobe and both error flags are registered, so each result appears on the clock edge that follows the request. `halt_issue` follows the flags in the same cycle. A register load only affects requests presented after its edge. The bench drives every stimulus on a falling edge and samples the ports on the next falling edge, which lands half a cycle after the single register stage. Expected addresses come from a model of the base and window end held in the bench, which is updated only when the bench itself loads a register.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
    typedef enum logic {
        KIND_FETCH   = 1'b0,
        KIND_OPERAND = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs #(
    parameter int RW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [RW-1:0] base_in,
    input  logic          end_we,
    input  logic [RW-1:0] end_in,
    output logic [RW-1:0] base_q,
    output logic [RW-1:0] end_q
);
    logic [RW-1:0] base_d, end_d;

    always_comb begin
        base_d = base_q;
        end_d  = end_q;
        if (base_we) base_d = base_in;
        if (end_we)  end_d  = end_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            end_q  <= '0;
        end else begin
            base_q <= base_d;
            end_q  <= end_d;
        end
    end

    // R9: registers move only on an explicit load
    assert_base_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !base_we |=> $stable(base_q));
    assert_end_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !end_we |=> $stable(end_q));
endmodule

// File: rtl/reloc_calc.sv
module reloc_calc #(
    parameter int AW        = 22,
    parameter int GRAN_BITS = 4,
    localparam int RW       = AW - GRAN_BITS
) (
    input  logic [RW-1:0] base,
    input  logic [RW-1:0] win_end,
    input  logic [AW-1:0] rel,
    output logic [AW-1:0] abs_addr,
    output logic          out_of_range
);
    logic [AW:0]   sum;
    logic [AW-1:0] end_abs;

    always_comb begin
        sum          = {1'b0, rel} + {1'b0, base, {GRAN_BITS{1'b0}}};
        end_abs      = {win_end, {GRAN_BITS{1'b0}}};
        abs_addr     = sum[AW-1:0];
        out_of_range = sum[AW] || (sum[AW-1:0] >= end_abs);
    end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard #(
    parameter int AW        = 22,
    parameter int GRAN_BITS = 4,
    localparam int RW       = AW - GRAN_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [RW-1:0] base_in,
    input  logic          end_we,
    input  logic [RW-1:0] end_in,
    input  logic          req_vld,
    input  logic          req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic          err_clr,
    output logic          abs_vld,
    output logic [AW-1:0] abs_addr,
    output logic          prog_err,
    output logic          oper_err,
    output logic          halt_issue
);
    import reloc_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic          perr;
        logic          oerr;
    } st_t;

    st_t st_d, st_q;
    logic [RW-1:0] base_q, end_q;
    logic [AW-1:0] calc_abs;
    logic          calc_oor;
    logic          fault;

    reloc_regs #(.RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_in(base_in),
        .end_we(end_we), .end_in(end_in),
        .base_q(base_q), .end_q(end_q)
    );

    reloc_calc #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_calc (
        .base(base_q), .win_end(end_q), .rel(req_addr),
        .abs_addr(calc_abs), .out_of_range(calc_oor)
    );

    always_comb begin
        st_d     = st_q;
        fault    = req_vld && calc_oor;
        st_d.vld = req_vld && !calc_oor;
        if (req_vld) st_d.addr = calc_abs;
        if (err_clr) begin
            st_d.perr = 1'b0;
            st_d.oerr = 1'b0;
        end
        if (fault) begin
            if (acc_kind_e'(req_kind) == KIND_FETCH) st_d.perr = 1'b1;
            else                                     st_d.oerr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign abs_vld    = st_q.vld;
    assign abs_addr   = st_q.addr;
    assign prog_err   = st_q.perr;
    assign oper_err   = st_q.oerr;
    assign halt_issue = st_q.perr | st_q.oerr;

    assert_fault_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && calc_oor) |=> !abs_vld);
    assert_inwin_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !calc_oor) |=> (abs_vld && abs_addr == $past(calc_abs)));
    assert_prog_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !err_clr) |=> prog_err);
    assert_oper_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oper_err && !err_clr) |=> oper_err);
    assert_prog_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_err) |-> $past(req_vld && calc_oor && req_kind == 1'b0));
    assert_oper_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oper_err) |-> $past(req_vld && calc_oor && req_kind == 1'b1));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !abs_vld);
endmodule

// File: tb/sim_reloc_guard.sv
module sim_reloc_guard;
    localparam int AW = 22;
    localparam int RW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          base_we = 1'b0, end_we = 1'b0;
    logic [RW-1:0] base_in = '0, end_in = '0;
    logic          req_vld = 1'b0, req_kind = 1'b0, err_clr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          abs_vld, prog_err, oper_err, halt_issue;
    logic [AW-1:0] abs_addr;

    int errors = 0;
    int checks = 0;
    logic [RW-1:0] m_base = '0, m_end = '0;
    logic m_perr = 1'b0, m_oerr = 1'b0;

    always #5 clk = ~clk;

    reloc_guard u0 (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_in(base_in),
        .end_we(end_we), .end_in(end_in),
        .req_vld(req_vld), .req_kind(req_kind), .req_addr(req_addr),
        .err_clr(err_clr),
        .abs_vld(abs_vld), .abs_addr(abs_addr),
        .prog_err(prog_err), .oper_err(oper_err), .halt_issue(halt_issue)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk({req, " prog_err"}, 32'(prog_err), 32'(m_perr));
        chk({req, " oper_err"}, 32'(oper_err), 32'(m_oerr));
        chk({req, " halt_issue (R8)"}, 32'(halt_issue), 32'(m_perr | m_oerr));
    endtask

    // one request, optional clear and optional base load in the same cycle
    task automatic access(input string req, input logic kind, input logic [AW-1:0] rel,
                          input logic clr, input logic ld, input logic [RW-1:0] nb);
        logic [AW:0] sum;
        logic        bad;
        sum = {1'b0, rel} + {1'b0, m_base, 4'b0};
        bad = sum[AW] || (sum[AW-1:0] >= {m_end, 4'b0});
        req_vld = 1'b1; req_kind = kind; req_addr = rel; err_clr = clr;
        base_we = ld; base_in = nb;
        @(negedge clk);
        req_vld = 1'b0; err_clr = 1'b0; base_we = 1'b0;
        if (ld) m_base = nb;
        if (clr) begin m_perr = 1'b0; m_oerr = 1'b0; end
        if (bad) begin
            if (kind) m_oerr = 1'b1; else m_perr = 1'b1;
        end
        chk({req, " abs_vld"}, 32'(abs_vld), 32'(!bad));
        if (!bad) chk({req, " abs_addr"}, 32'(abs_addr), 32'(sum[AW-1:0]));
        chk_flags(req);
    endtask

    task automatic load(input logic [RW-1:0] b, input logic [RW-1:0] e);
        base_we = 1'b1; base_in = b; end_we = 1'b1; end_in = e;
        @(negedge clk);
        base_we = 1'b0; end_we = 1'b0;
        m_base = b; m_end = e;
    endtask

    task automatic clear_flags();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        m_perr = 1'b0; m_oerr = 1'b0;
        chk_flags("R7 clear");
    endtask

    task automatic t_reset();
        chk("R1 abs_vld", 32'(abs_vld), 0);
        chk_flags("R1");
        // window end is zero after reset, so even relative 0 is out of range
        access("R1 end zero", 1'b1, 22'h0, 1'b0, 1'b0, '0);
        clear_flags();
    endtask

    task automatic t_translate();
        load(18'h10, 18'h100);
        access("R2 low", 1'b0, 22'h5, 1'b0, 1'b0, '0);
        access("R2 operand", 1'b1, 22'h7A3, 1'b0, 1'b0, '0);
        load(18'h0, 18'h3FFFF);
        access("R2 zero base", 1'b1, 22'h12345, 1'b0, 1'b0, '0);
    endtask

    task automatic t_boundary();
        load(18'h10, 18'h100);
        access("R3 last in", 1'b0, 22'hEFF, 1'b0, 1'b0, '0);
        access("R3 first out R5 R6", 1'b0, 22'hF00, 1'b0, 1'b0, '0);
        access("R7 sticky after good", 1'b1, 22'h10, 1'b0, 1'b0, '0);
        access("R5 operand fault", 1'b1, 22'h3FFFFF, 1'b0, 1'b0, '0);
        clear_flags();
        access("R7 set beats clear", 1'b1, 22'hF00, 1'b1, 1'b0, '0);
        clear_flags();
    endtask

    task automatic t_carry();
        load(18'h3FFFF, 18'h3FFFF);
        // sum = 0x400010: carry out, low bits 0x10 are below the window end
        access("R4 carry", 1'b0, 22'h20, 1'b0, 1'b0, '0);
        clear_flags();
    endtask

    task automatic t_load_timing();
        load(18'h10, 18'h200);
        access("R9 old base in load cycle", 1'b0, 22'h4, 1'b0, 1'b1, 18'h20);
        access("R9 new base after", 1'b0, 22'h4, 1'b0, 1'b0, '0);
        access("R9 base unchanged", 1'b1, 22'h4, 1'b0, 1'b0, '0);
    endtask

    task automatic t_idle();
        load(18'h0, 18'h1);
        access("R10 prep fault", 1'b0, 22'h10, 1'b0, 1'b0, '0);
        req_addr = 22'h3FFFFF;
        @(negedge clk);
        chk("R10 idle abs_vld", 32'(abs_vld), 0);
        chk_flags("R10 idle");
        clear_flags();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_translate();
        t_boundary();
        t_carry();
        t_load_timing();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule